// File: doc/BRIEF.md
# Menu-driven SPI flash cycle sequencer

This block is a SPI flash master that software drives through a small word-addressed register port. Software first loads a table of eight opcodes. Each table entry has a 2-bit kind code. Software also loads a prefix opcode, a 24-bit flash address and up to 64 data bytes. A single control write then picks a table entry, sets the byte count and starts one flash cycle. The block drives chip select, clock and data out in SPI mode 0.

A cycle can begin with the prefix opcode, normally a write enable, sent as a separate chip-select frame. The main frame follows directly, so no other transfer can come between the two. The main frame carries:
- the opcode;
- the three address bytes, when the entry's kind has an address;
- then either the outgoing data bytes or the captured read bytes.

Status reports the busy, done and error conditions. A sticky lock freezes the opcode table, the kind register and the prefix register until reset. A speed bit selects the faster of two SPI clock rates.

The register port has no back-pressure. A write is taken in the clock cycle in which `reg_wr` is high. Read data is combinational from `reg_addr`. The SPI pins are plain levels.

Top module: `menu_spi_seq`

## Requirements
- R1: After reset, the control and status registers read 0, `spi_cs_n` is high and `spi_sck` is low. Register word addresses:
  - 0 control, 1 status, 2 address, 3 prefix, 4 kind, 5 opcode table low, 6 opcode table high;
  - 16 to 31 data buffer.
- R2: The main frame starts with table entry `i`, where `i` is control bits 6:4. Entry `i` is held in table-low bits `8i+7:8i` for i<4, and in table-high for i≥4. The kind of entry `i` is kind-register bits `2i+1:2i`. In the kind code, bit 1 means "has address" and bit 0 means "write". So 0 is read without address, 1 is write without address, 2 is read with address and 3 is write with address.
- R3: Frames use SPI mode 0. Bits go out MSB first. The address is sent as 24 bits, high byte first. Address register bits 31:24 are dropped and read back as 0.
- R4: Control bit 14 enables a data phase. Bits 13:8 then hold the byte count minus one, for 1 to 64 bytes. Buffer byte `n` sits at word `16+n/4`, bits `8(n%4)+7:8(n%4)`. A write cycle sends buffer bytes in order 0 upward. A read cycle stores each received byte at the same position. Data-buffer writes from the host are ignored while busy.
- R5: When control bit 1 is set, the prefix register's opcode is first sent as its own 8-bit frame. Chip select then stays high for one SPI clock period, and the main frame follows.
- R6: Status bit 0 is busy. It is high from the accepted go (control bit 0) until the last bit of the main frame. Status bit 1 (done) is set when a cycle ends. Status bit 2 (error) is set when a go is rejected. Writing 1 to bit 1 or bit 2 clears that bit.
- R7: A control write while busy has no effect. The running cycle completes unchanged, and control reads back its previous value.
- R8: A go whose selected entry is a read kind, with control bit 14 clear, sets error and drives no frame.
- R9: Writing 1 to status bit 8 sets the lock. The lock stays set until reset. While locked, writes to the prefix, kind and table registers are ignored.
- R10: Control bit 16 selects the fast SPI clock, with a period of 2·HALF_FAST system clocks (32 ns at the defaults). When it is clear, the period is 2·HALF_SLOW clocks (48 ns).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong sequencer state appears directly on the pins. One of three things happens:
- a frame has the wrong length;
- the opcode, address or data bits land in the wrong place;
- the clock toggles while chip select is high.

The flash model checks these at the end of each frame. A wrong latched kind or a wrong byte position shows up as soon as the cycle's done bit can be polled. It appears either as a mismatched frame or as wrong read-back words. Lock and busy gating errors appear on the very next register read.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int BUF_BYTES = 64;
  localparam int CNT_W     = $clog2(BUF_BYTES);
  localparam int AW        = CNT_W - 1;
  localparam int BPW       = $clog2(32 + 8 * BUF_BYTES) + 1;

  localparam logic [AW-1:0] A_CTRL   = AW'(0);
  localparam logic [AW-1:0] A_STAT   = AW'(1);
  localparam logic [AW-1:0] A_ADDR   = AW'(2);
  localparam logic [AW-1:0] A_PREFIX = AW'(3);
  localparam logic [AW-1:0] A_KIND   = AW'(4);
  localparam logic [AW-1:0] A_TBL_LO = AW'(5);
  localparam logic [AW-1:0] A_TBL_HI = AW'(6);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_GAP, ST_MAIN} seq_state_e;

  typedef struct packed {
    logic             fast;
    logic             dflag;
    logic [CNT_W-1:0] cnt_m1;
    logic [2:0]       idx;
    logic             pre;
  } cyc_ctl_t;
endpackage

// File: rtl/mss_clkdiv.sv
module mss_clkdiv #(
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW   = $clog2(MAXH) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  generate
    if (HALF_SLOW == HALF_FAST) begin : g_one_rate
      assign lim = CW'(HALF_SLOW - 1);
    end else begin : g_two_rate
      assign lim = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
    end
  endgenerate

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mss_regs.sv
module mss_regs
  import mss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             eng_wr,
  input  logic [CNT_W-1:0] eng_widx,
  input  logic [7:0]       eng_wbyte,
  input  logic [CNT_W-1:0] eng_ridx,
  output logic [7:0]       eng_rbyte,
  output logic             go,
  output cyc_ctl_t         ctl_next,
  output logic [23:0]      faddr,
  output logic [7:0]       prefix,
  output logic [15:0]      kind,
  output logic [63:0]      table_q
);
  logic [7:0] dbuf [BUF_BYTES];
  cyc_ctl_t   ctl_q;
  logic       done_q, err_q, lock_q;
  logic       wr_ctrl, wr_stat;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign go       = wr_ctrl && wdata[0] && !busy;
  assign ctl_next = '{fast: wdata[16], dflag: wdata[14], cnt_m1: wdata[8 +: CNT_W],
                      idx: wdata[6:4], pre: wdata[1]};
  assign eng_rbyte = dbuf[eng_ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      faddr <= '0; prefix <= '0; kind <= '0; table_q <= '0;
    end else begin
      if (wr_ctrl && !busy) ctl_q <= ctl_next;
      if (eng_done)                done_q <= 1'b1;
      else if (wr_stat && wdata[1]) done_q <= 1'b0;
      if (eng_err)                 err_q <= 1'b1;
      else if (wr_stat && wdata[2]) err_q <= 1'b0;
      if (wr_stat && wdata[8]) lock_q <= 1'b1;
      if (wr_en && addr == A_ADDR) faddr <= wdata[23:0];
      if (wr_en && !lock_q) begin
        if (addr == A_PREFIX) prefix <= wdata[7:0];
        if (addr == A_KIND)   kind <= wdata[15:0];
        if (addr == A_TBL_LO) table_q[31:0] <= wdata;
        if (addr == A_TBL_HI) table_q[63:32] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (eng_wr) dbuf[eng_widx] <= eng_wbyte;
    else if (wr_en && addr[AW-1] && !busy)
      for (int k = 0; k < 4; k++)
        dbuf[{addr[AW-2:0], 2'(k)}] <= wdata[8*k +: 8];
  end

  always_comb begin
    rdata = '0;
    if (addr[AW-1]) begin
      for (int k = 0; k < 4; k++) rdata[8*k +: 8] = dbuf[{addr[AW-2:0], 2'(k)}];
    end else begin
      unique case (addr)
        A_CTRL: begin
          rdata[16] = ctl_q.fast;  rdata[14] = ctl_q.dflag;
          rdata[8 +: CNT_W] = ctl_q.cnt_m1;
          rdata[6:4] = ctl_q.idx;  rdata[1] = ctl_q.pre;
        end
        A_STAT:   rdata = {23'b0, lock_q, 5'b0, err_q, done_q, busy};
        A_ADDR:   rdata = {8'b0, faddr};
        A_PREFIX: rdata = {24'b0, prefix};
        A_KIND:   rdata = {16'b0, kind};
        A_TBL_LO: rdata = table_q[31:0];
        A_TBL_HI: rdata = table_q[63:32];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mss_engine.sv
module mss_engine
  import mss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  cyc_ctl_t         ctl,
  input  logic [23:0]      faddr,
  input  logic [7:0]       prefix,
  input  logic [15:0]      kind,
  input  logic [63:0]      table_q,
  input  logic             tick,
  input  logic             miso,
  input  logic [7:0]       rbyte,
  output logic [CNT_W-1:0] ridx,
  output logic             busy,
  output logic             fast,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic             done_p,
  output logic             err_p,
  output logic             wr,
  output logic [CNT_W-1:0] widx,
  output logic [7:0]       wbyte
);
  localparam logic [BPW-1:0] B7  = BPW'(7);
  localparam logic [BPW-1:0] B8  = BPW'(8);
  localparam logic [BPW-1:0] B32 = BPW'(32);

  seq_state_e     st;
  logic [7:0]     opc, pre_op;
  logic [23:0]    adr;
  logic           has_addr, is_wr, has_data, gap;
  logic [BPW-1:0] bpos, last, last_calc, dstart, dfull;
  logic [6:0]     rxsh;
  logic [1:0]     sel_t;
  logic [7:0]     sel_op;
  logic [2:0]     dbit;
  logic           in_data;

  assign sel_t   = kind[ctl.idx*2 +: 2];
  assign sel_op  = table_q[ctl.idx*8 +: 8];
  assign dstart  = has_addr ? B32 : B8;
  assign dfull   = bpos - dstart;
  assign in_data = has_data && !dfull[BPW-1] && (dfull[BPW-2:CNT_W+3] == '0);
  assign ridx    = dfull[CNT_W+2:3];
  assign dbit    = dfull[2:0];
  assign busy    = (st != ST_IDLE);
  assign cs_n    = !(st == ST_PRE || st == ST_MAIN);
  assign last_calc = B7 + (sel_t[1] ? BPW'(24) : '0)
                   + (ctl.dflag ? (BPW'({ctl.cnt_m1, 3'b000}) + B8) : '0);

  always_comb begin
    mosi = 1'b0;
    if (st == ST_PRE) mosi = pre_op[3'd7 - bpos[2:0]];
    else if (st == ST_MAIN) begin
      if (bpos < B8)                   mosi = opc[3'd7 - bpos[2:0]];
      else if (has_addr && bpos < B32) mosi = adr[5'd31 - bpos[4:0]];
      else if (is_wr)                  mosi = rbyte[3'd7 - dbit];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sck <= 1'b0; bpos <= '0; last <= '0; opc <= '0; pre_op <= '0;
      adr <= '0; has_addr <= 1'b0; is_wr <= 1'b0; has_data <= 1'b0; fast <= 1'b0;
      rxsh <= '0; gap <= 1'b0; done_p <= 1'b0; err_p <= 1'b0; wr <= 1'b0;
      widx <= '0; wbyte <= '0;
    end else begin
      done_p <= 1'b0; err_p <= 1'b0; wr <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          sck <= 1'b0;
          if (go) begin
            if (!sel_t[0] && !ctl.dflag) err_p <= 1'b1;
            else begin
              opc <= sel_op; pre_op <= prefix; adr <= faddr;
              has_addr <= sel_t[1]; is_wr <= sel_t[0]; has_data <= ctl.dflag;
              fast <= ctl.fast; bpos <= '0; last <= last_calc;
              st <= ctl.pre ? ST_PRE : ST_MAIN;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap) begin gap <= 1'b0; st <= ST_MAIN; end
          else gap <= 1'b1;
        end
        default: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (st == ST_MAIN && in_data && !is_wr) begin
              rxsh <= {rxsh[5:0], miso};
              if (dbit == 3'd7) begin wr <= 1'b1; widx <= ridx; wbyte <= {rxsh, miso}; end
            end
          end else begin
            sck <= 1'b0;
            if (st == ST_PRE && bpos == B7) begin st <= ST_GAP; bpos <= '0; gap <= 1'b0; end
            else if (st == ST_MAIN && bpos == last) begin st <= ST_IDLE; done_p <= 1'b1; end
            else bpos <= bpos + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/menu_spi_seq.sv
module menu_spi_seq
  import mss_pkg::*;
#(
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  logic             busy_w, done_w, err_w, go_w, tick_w, fast_w, ewr_w;
  cyc_ctl_t         ctl_w;
  logic [23:0]      faddr_w;
  logic [7:0]       prefix_w, wbyte_w, rbyte_w;
  logic [15:0]      kind_w;
  logic [63:0]      table_w;
  logic [CNT_W-1:0] widx_w, ridx_w;

  mss_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy_w), .eng_done(done_w), .eng_err(err_w),
    .eng_wr(ewr_w), .eng_widx(widx_w), .eng_wbyte(wbyte_w), .eng_ridx(ridx_w),
    .eng_rbyte(rbyte_w), .go(go_w), .ctl_next(ctl_w), .faddr(faddr_w),
    .prefix(prefix_w), .kind(kind_w), .table_q(table_w)
  );

  mss_clkdiv #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .fast(fast_w), .tick(tick_w)
  );

  mss_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(go_w), .ctl(ctl_w), .faddr(faddr_w),
    .prefix(prefix_w), .kind(kind_w), .table_q(table_w), .tick(tick_w),
    .miso(spi_miso), .rbyte(rbyte_w), .ridx(ridx_w), .busy(busy_w), .fast(fast_w),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .done_p(done_w), .err_p(err_w),
    .wr(ewr_w), .widx(widx_w), .wbyte(wbyte_w)
  );
endmodule

// File: rtl/menu_spi_seq_chk.sv
module menu_spi_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic busy,
  input logic done_p,
  input logic err_p
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R3
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R3
  AST_FRAME_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> busy); // R6
  AST_DONE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_p |-> (!busy && spi_cs_n)); // R6
  AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) err_p |-> (spi_cs_n && !busy)); // R8
endmodule

bind menu_spi_seq menu_spi_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .busy(busy_w), .done_p(done_w), .err_p(err_w)
);

// File: tb/tb_menu_spi_seq.sv
module tb_menu_spi_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, cs_n, mosi;
  logic        miso = 1'b0;

  menu_spi_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic patbit(input int n);
    return ((n * 13 + (n >> 3)) % 7) < 3;
  endfunction
  function automatic logic [7:0] dbyte(input int n);
    return 8'(n * 37 + 5);
  endfunction
  function automatic logic [7:0] rxbyte(input int start);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7-j] = patbit(start + j);
    return b;
  endfunction
  function automatic logic [31:0] cw(input int idx, input bit pre, input bit df, input int cnt, input bit fast);
    logic [31:0] w;
    w = 32'h1; w[1] = pre; w[6:4] = 3'(idx); w[13:8] = 6'(cnt); w[14] = df; w[16] = fast;
    return w;
  endfunction

  // flash-side model
  logic [1023:0] cur;
  int            ccnt;
  int            fq_n[$];
  logic [1023:0] fq_v[$];
  realtime       last_rise;
  realtime       sck_per;
  always @(negedge cs_n) begin ccnt = 0; cur = '0; miso <= patbit(0); end
  always @(posedge sck) if (!cs_n) begin
    if (ccnt > 0) sck_per = $realtime - last_rise;
    last_rise = $realtime;
    cur = {cur[1022:0], mosi}; ccnt++;
  end
  always @(negedge sck) if (!cs_n) miso <= patbit(ccnt);
  always @(posedge cs_n) if (rst_n) begin fq_n.push_back(ccnt); fq_v.push_back(cur); end

  // per-clock reference comparison: mode-0 idle level (R3)
  always @(negedge clk) if (rst_n) begin
    vectors++;
    if (cs_n && sck) begin miscompares++; $display("FAIL R3 sck=1 with cs_n=1 actual=1 expected=0"); end
  end

  logic [1023:0] ev;
  int            en;
  task automatic ev_clear; ev = '0; en = 0; endtask
  task automatic ev_add(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin ev = {ev[1022:0], v[i]}; en++; end
  endtask
  task automatic exp_frame(input string req);
    int n; logic [1023:0] v;
    if (fq_n.size() == 0) chk(0, req, 0, 64'(en));
    else begin
      n = fq_n.pop_front(); v = fq_v.pop_front();
      chk(n == en && v == ev, req, (n == en) ? v[63:0] : 64'(n), (n == en) ? ev[63:0] : 64'(en));
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_done(input string req);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin rd(5'd1, s); if (s[1]) break; end
    chk(s[1] == 1'b1, req, 64'(s), 64'h2);
    wr(5'd1, 32'h6);
  endtask

  logic [7:0] tbl [8] = '{8'h9F, 8'h01, 8'h03, 8'h02, 8'h20, 8'h05, 8'h04, 8'h0B};
  int         kd  [8] = '{0, 1, 2, 3, 3, 0, 1, 2};

  initial begin : main
    logic [31:0] r, kw, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'd0, r); chk(r == 0, "R1 ctrl reset", 64'(r), 0);
    rd(5'd1, r); chk(r == 0, "R1 status reset", 64'(r), 0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins reset", {cs_n, sck}, 64'h2);

    kw = 0; lo = 0; hi = 0;
    for (int i = 0; i < 8; i++) begin
      kw |= 32'(kd[i]) << (2 * i);
      if (i < 4) lo[8*i +: 8] = tbl[i]; else hi[8*(i-4) +: 8] = tbl[i];
    end
    wr(5'd4, kw); wr(5'd5, lo); wr(5'd6, hi); wr(5'd3, 32'h06);
    wr(5'd2, 32'hFF123456);
    rd(5'd2, r); chk(r == 32'h123456, "R3 address upper bits dropped", 64'(r), 64'h123456);
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {dbyte(4*w+3), dbyte(4*w+2), dbyte(4*w+1), dbyte(4*w)});

    // erase with prefix, slow clock
    wr(5'd0, cw(4, 1, 0, 0, 0));
    wait_done("R6 erase done");
    ev_clear(); ev_add(32'h06, 8); exp_frame("R5 prefix frame");
    ev_clear(); ev_add(32'h20, 8); ev_add(32'h123456, 24); exp_frame("R3 R2 erase frame");
    chk(sck_per == 48.0, "R10 slow period", 64'(int'(sck_per)), 48);

    // program 5 bytes
    wr(5'd0, cw(3, 0, 1, 4, 0));
    wait_done("R6 program done");
    ev_clear(); ev_add(32'h02, 8); ev_add(32'h123456, 24);
    for (int n = 0; n < 5; n++) ev_add(32'(dbyte(n)), 8);
    exp_frame("R4 program 5 bytes");

    // program full 64 bytes
    wr(5'd0, cw(3, 0, 1, 63, 0));
    wait_done("R6 program 64 done");
    ev_clear(); ev_add(32'h02, 8); ev_add(32'h123456, 24);
    for (int n = 0; n < 64; n++) ev_add(32'(dbyte(n)), 8);
    exp_frame("R4 program 64 bytes");

    // write without address
    wr(5'd0, cw(1, 0, 1, 0, 0));
    wait_done("R6 wrsr done");
    ev_clear(); ev_add(32'h01, 8); ev_add(32'(dbyte(0)), 8);
    exp_frame("R2 write no address");

    // read without address, 3 bytes
    wr(5'd0, cw(0, 0, 1, 2, 0));
    wait_done("R6 id done");
    ev_clear(); ev_add(32'h9F, 8); ev_add(32'h0, 24); exp_frame("R2 read no address frame");
    rd(5'd16, r);
    chk(r[23:0] == {rxbyte(24), rxbyte(16), rxbyte(8)}, "R4 read no address capture",
        64'(r[23:0]), 64'({rxbyte(24), rxbyte(16), rxbyte(8)}));

    // read with address, 4 bytes, fast clock
    wr(5'd0, cw(2, 0, 1, 3, 1));
    wait_done("R6 read done");
    ev_clear(); ev_add(32'h03, 8); ev_add(32'h123456, 24); ev_add(32'h0, 32);
    exp_frame("R2 read with address frame");
    chk(sck_per == 32.0, "R10 fast period", 64'(int'(sck_per)), 32);
    rd(5'd16, r);
    chk(r == {rxbyte(56), rxbyte(48), rxbyte(40), rxbyte(32)}, "R4 read capture",
        64'(r), 64'({rxbyte(56), rxbyte(48), rxbyte(40), rxbyte(32)}));

    // rejected go
    wr(5'd0, cw(5, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(5'd1, r); chk(r[2:0] == 3'b100, "R8 error set", 64'(r[2:0]), 4);
    chk(fq_n.size() == 0, "R8 no frame", 64'(fq_n.size()), 0);
    wr(5'd1, 32'h4);
    rd(5'd1, r); chk(r[2] == 1'b0, "R6 error W1C", 64'(r[2]), 0);

    // go while busy
    wr(5'd0, cw(3, 0, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd(5'd1, r); chk(r[0] == 1'b1 && cs_n == 1'b0, "R6 busy during frame", {r[0], cs_n}, 64'h2);
    wr(5'd0, cw(0, 1, 1, 7, 1));
    wait_done("R7 first cycle done");
    ev_clear(); ev_add(32'h02, 8); ev_add(32'h123456, 24); ev_add(32'(rxbyte(32)), 8);
    exp_frame("R7 running cycle unchanged");
    chk(fq_n.size() == 0, "R7 no second frame", 64'(fq_n.size()), 0);
    rd(5'd0, r); chk(r == (cw(3, 0, 1, 0, 0) & ~32'h1), "R7 ctrl unchanged", 64'(r), 64'(cw(3, 0, 1, 0, 0) & ~32'h1));
    rd(5'd1, r); chk(r[1] == 1'b0, "R6 done W1C", 64'(r[1]), 0);

    // lockdown
    wr(5'd1, 32'h100);
    wr(5'd5, 32'h0); wr(5'd6, 32'h0); wr(5'd4, 32'h0); wr(5'd3, 32'h0);
    rd(5'd5, r); chk(r == lo, "R9 table low locked", 64'(r), 64'(lo));
    rd(5'd6, r); chk(r == hi, "R9 table high locked", 64'(r), 64'(hi));
    rd(5'd4, r); chk(r == kw, "R9 kind locked", 64'(r), 64'(kw));
    rd(5'd3, r); chk(r == 32'h06, "R9 prefix locked", 64'(r), 6);
    wr(5'd1, 32'h0);
    rd(5'd1, r); chk(r[8] == 1'b1, "R9 lock sticky", 64'(r[8]), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule